// File: doc/BRIEF.md
# Legacy Video Access Router

This block sorts each access to the legacy video resources of a PC-style system and picks the one agent that serves it. An access is either a memory access or an I/O access. Its address is checked against the legacy colour video window, the monochrome-adapter subset of that window, and the standard video and monochrome I/O port sets. Three kinds of agent can serve it: the on-chip graphics engine, one of several bridge ports toward add-in cards, and the downstream legacy interface. The downstream interface also takes every access that no other agent claims.

Each request is presented for one cycle with `req_valid_i`. The block registers its decision, and one cycle later it shows a one-hot destination with `dest_valid_o`. The routing inputs are treated as static configuration. They are sampled together with the request, so a change to them takes effect on the next request.

Top module: `vga_legacy_decoder`

## Requirements
- R1: While `rst_ni` is low, `dest_valid_o` is 0 and `dest_o` is all zeros.
- R2: A request sampled on a rising edge gives `dest_valid_o`=1 after that edge and exactly one set bit in `dest_o`. When no request was sampled, `dest_valid_o`=0 and `dest_o` is all zeros. Bit encoding of `dest_o`: bit 0 is the on-chip graphics engine, bit k+1 is bridge port k, and the top bit (NPORT+1) is the downstream legacy interface.
- R3: Memory addresses 0xA0000 through 0xBFFFF, with all higher address bits zero, go to the current video target.
- R4: I/O ports 0x3B0 through 0x3BB and 0x3C0 through 0x3DF go to the current video target.
- R5: When `igd_en_i`=1, the on-chip graphics engine is the video target, whatever the per-port enables are.
- R6: When `igd_en_i`=0, the video target is the lowest-numbered bridge port whose bit in `vga_en_i` is 1.
- R7: An access goes to the downstream interface when no video target is enabled, or when it falls outside the video memory window and the video port sets.
- R8: When `mda_present_i`=1, memory 0xB0000 through 0xB7FFF and I/O ports 0x3B4, 0x3B5, 0x3B8, 0x3B9, 0x3BA and 0x3BF go to the downstream interface. Memory 0xB8000 through 0xBFFFF and the remaining video ports still follow R3 and R4.
- R9: When `decode16_i`=0, only I/O address bits 9:0 are compared, so aliases such as 0x73C0 match. When `decode16_i`=1, I/O address bits 15:10 must be zero for a match.
- R10: I/O ports 0x3BC through 0x3BF are not video ports. With `mda_present_i`=0 they go to the downstream interface.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| is_io_i | input | 1 | 1 = I/O access, 0 = memory access |
| addr_i | input | AW | Access address (I/O uses bits 15:0) |
| vga_en_i | input | NPORT | Per-bridge-port video steering enable |
| mda_present_i | input | 1 | Monochrome adapter sits on the downstream interface |
| decode16_i | input | 1 | 1 = full 16-bit I/O compare, 0 = 10-bit compare |
| igd_en_i | input | 1 | On-chip graphics engine enabled as video target |
| dest_valid_o | output | 1 | Destination valid, one cycle after the request |
| dest_o | output | NPORT+2 | One-hot destination |

## Verification
The only state is the registered decision, so any fault shows at the ports one cycle after the request that exposed it. A wrong class match appears as a swap between the video target and the downstream bit. A fault in port priority appears as a higher-numbered port winning when several ports are enabled. A corrupted output register appears as zero or two set destination bits, or as a valid flag without a matching request. The directed cases sit at the edges of each window and port range. Each configuration bit is toggled around a fixed address, so one wrong decision is traced to one cause.

// File: rtl/vga_dec_pkg.sv
package vga_dec_pkg;
  typedef struct packed {
    logic vid_mem;
    logic mono_mem;
    logic vid_io;
    logic mono_io;
  } acc_class_t;

  localparam logic [19:0] VID_MEM_LO  = 20'hA0000;
  localparam logic [19:0] VID_MEM_HI  = 20'hBFFFF;
  localparam logic [19:0] MONO_MEM_LO = 20'hB0000;
  localparam logic [19:0] MONO_MEM_HI = 20'hB7FFF;
endpackage

// File: rtl/vga_dec_classify.sv
module vga_dec_classify
  import vga_dec_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          is_io_i,
  input  logic [AW-1:0] addr_i,
  input  logic          decode16_i,
  output acc_class_t    cls_o
);
  localparam logic [AW-1:0] VLO = AW'(VID_MEM_LO);
  localparam logic [AW-1:0] VHI = AW'(VID_MEM_HI);
  localparam logic [AW-1:0] MLO = AW'(MONO_MEM_LO);
  localparam logic [AW-1:0] MHI = AW'(MONO_MEM_HI);

  logic [9:0] port_lo;
  logic       hi_ok;
  logic       vid_port;
  logic       mono_port;

  assign port_lo = addr_i[9:0];
  // 10-bit decode aliases every 1 KB of I/O space
  assign hi_ok   = !decode16_i || (addr_i[15:10] == 6'd0);

  always_comb begin
    vid_port = ((port_lo >= 10'h3B0) && (port_lo <= 10'h3BB)) ||
               ((port_lo >= 10'h3C0) && (port_lo <= 10'h3DF));
    unique case (port_lo)
      10'h3B4, 10'h3B5, 10'h3B8,
      10'h3B9, 10'h3BA, 10'h3BF: mono_port = 1'b1;
      default:                   mono_port = 1'b0;
    endcase
  end

  always_comb begin
    cls_o.vid_mem  = !is_io_i && (addr_i >= VLO) && (addr_i <= VHI);
    cls_o.mono_mem = !is_io_i && (addr_i >= MLO) && (addr_i <= MHI);
    cls_o.vid_io   = is_io_i && hi_ok && vid_port;
    cls_o.mono_io  = is_io_i && hi_ok && mono_port;
  end
endmodule

// File: rtl/vga_dec_port_pick.sv
module vga_dec_port_pick #(
  parameter int NPORT = 2
) (
  input  logic [NPORT-1:0] en_i,
  output logic [NPORT-1:0] sel_o,
  output logic             any_o
);
  logic [NPORT:0] seen;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < NPORT; g++) begin : g_pick
    assign sel_o[g]    = en_i[g] & ~seen[g];
    assign seen[g + 1] = seen[g] | en_i[g];
  end
  assign any_o = seen[NPORT];
endmodule

// File: rtl/vga_legacy_decoder.sv
module vga_legacy_decoder
  import vga_dec_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NPORT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             is_io_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NPORT-1:0] vga_en_i,
  input  logic             mda_present_i,
  input  logic             decode16_i,
  input  logic             igd_en_i,
  output logic             dest_valid_o,
  output logic [NPORT+1:0] dest_o
);
  localparam int DW = NPORT + 2;

  acc_class_t       cls;
  logic [NPORT-1:0] port_sel;
  logic             port_any;
  logic             vid_hit;
  logic             mono_hit;
  logic [DW-1:0]    dest_nxt;

  vga_dec_classify #(.AW(AW)) u_cls (
    .is_io_i   (is_io_i),
    .addr_i    (addr_i),
    .decode16_i(decode16_i),
    .cls_o     (cls)
  );

  vga_dec_port_pick #(.NPORT(NPORT)) u_pick (
    .en_i (vga_en_i),
    .sel_o(port_sel),
    .any_o(port_any)
  );

  assign vid_hit  = cls.vid_mem | cls.vid_io;
  assign mono_hit = cls.mono_mem | cls.mono_io;

  // on-chip target first, then bridge ports, downstream last
  always_comb begin
    dest_nxt = '0;
    if ((mda_present_i && mono_hit) || !vid_hit) dest_nxt[DW-1] = 1'b1;
    else if (igd_en_i)                           dest_nxt[0] = 1'b1;
    else if (port_any)                           dest_nxt[NPORT:1] = port_sel;
    else                                         dest_nxt[DW-1] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dest_valid_o <= 1'b0;
      dest_o       <= '0;
    end else begin
      dest_valid_o <= req_valid_i;
      dest_o       <= req_valid_i ? dest_nxt : '0;
    end
  end
endmodule

// File: rtl/vga_legacy_decoder_chk.sv
module vga_legacy_decoder_chk #(
  parameter int AW    = 32,
  parameter int NPORT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             is_io_i,
  input logic [AW-1:0]    addr_i,
  input logic             mda_present_i,
  input logic             decode16_i,
  input logic             igd_en_i,
  input logic             dest_valid_o,
  input logic [NPORT+1:0] dest_o
);
  localparam int DW = NPORT + 2;
  localparam logic [AW-1:0] VLO = AW'(20'hA0000);
  localparam logic [AW-1:0] VHI = AW'(20'hBFFFF);
  localparam logic [AW-1:0] ALO = AW'(20'hAFFFF);

  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dest_valid_o |-> (dest_o == '0)); // R2
  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_valid_o |-> ($countones(dest_o) == 1)); // R2
  AST_RESULT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> dest_valid_o); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !dest_valid_o); // R2
  AST_OUTSIDE_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !is_io_i && ((addr_i < VLO) || (addr_i > VHI)))
    |=> dest_o[DW-1]); // R7
  AST_ONCHIP_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && igd_en_i && !is_io_i && (addr_i >= VLO) && (addr_i <= ALO))
    |=> dest_o[0]); // R5
  AST_MONO_PORT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && is_io_i && mda_present_i && !decode16_i && (addr_i[9:0] == 10'h3BF))
    |=> dest_o[DW-1]); // R8
  AST_FULL_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && is_io_i && decode16_i && (addr_i[15:10] != 6'd0))
    |=> dest_o[DW-1]); // R9
endmodule

bind vga_legacy_decoder vga_legacy_decoder_chk #(.AW(AW), .NPORT(NPORT)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .is_io_i      (is_io_i),
  .addr_i       (addr_i),
  .mda_present_i(mda_present_i),
  .decode16_i   (decode16_i),
  .igd_en_i     (igd_en_i),
  .dest_valid_o (dest_valid_o),
  .dest_o       (dest_o)
);

// File: tb/vga_legacy_decoder_tb_top.sv
module vga_legacy_decoder_tb_top;
  localparam int AW    = 32;
  localparam int NPORT = 2;
  localparam logic [3:0] ONC = 4'b0001;
  localparam logic [3:0] P0  = 4'b0010;
  localparam logic [3:0] P1  = 4'b0100;
  localparam logic [3:0] DS  = 4'b1000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             is_io = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [NPORT-1:0] vga_en = '0;
  logic             mda = 1'b0;
  logic             d16 = 1'b0;
  logic             igd = 1'b0;
  logic             dest_valid;
  logic [3:0]       dest;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vga_legacy_decoder #(.AW(AW), .NPORT(NPORT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .is_io_i(is_io),
    .addr_i(addr), .vga_en_i(vga_en), .mda_present_i(mda), .decode16_i(d16),
    .igd_en_i(igd), .dest_valid_o(dest_valid), .dest_o(dest)
  );

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive at negedge, sampled at next posedge, observed at the following negedge
  task automatic probe(string req, logic io, logic [AW-1:0] a, logic [1:0] en,
                       logic m, logic w16, logic g, logic [3:0] exp);
    @(negedge clk);
    req_valid = 1'b1; is_io = io; addr = a; vga_en = en; mda = m; d16 = w16; igd = g;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {dest_valid, dest}, {1'b1, exp});
  endtask

  task automatic t_reset;
    #1;
    check("R1", {dest_valid, dest}, 5'b0);
    repeat (3) @(negedge clk);
    check("R1", {dest_valid, dest}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 idle", {dest_valid, dest}, 5'b0);
  endtask

  task automatic t_mem_window;
    probe("R3 lo edge",   1'b0, 32'h000A0000, 2'b00, 1'b0, 1'b0, 1'b1, ONC);
    probe("R3 hi edge",   1'b0, 32'h000BFFFF, 2'b00, 1'b0, 1'b0, 1'b1, ONC);
    probe("R7 below",     1'b0, 32'h0009FFFF, 2'b00, 1'b0, 1'b0, 1'b1, DS);
    probe("R7 above",     1'b0, 32'h000C0000, 2'b00, 1'b0, 1'b0, 1'b1, DS);
    probe("R7 high bits", 1'b0, 32'h100A0000, 2'b00, 1'b0, 1'b0, 1'b1, DS);
  endtask

  task automatic t_priority;
    probe("R5 over ports", 1'b0, 32'h000A5000, 2'b11, 1'b0, 1'b0, 1'b1, ONC);
    probe("R6 lowest",     1'b0, 32'h000A5000, 2'b11, 1'b0, 1'b0, 1'b0, P0);
    probe("R6 port1",      1'b0, 32'h000A5000, 2'b10, 1'b0, 1'b0, 1'b0, P1);
    probe("R7 no target",  1'b0, 32'h000A5000, 2'b00, 1'b0, 1'b0, 1'b0, DS);
    probe("R7 io no tgt",  1'b1, 32'h000003C0, 2'b00, 1'b0, 1'b0, 1'b0, DS);
  endtask

  task automatic t_io_ports;
    probe("R4 3C0", 1'b1, 32'h3C0, 2'b00, 1'b0, 1'b0, 1'b1, ONC);
    probe("R4 3DF", 1'b1, 32'h3DF, 2'b01, 1'b0, 1'b0, 1'b0, P0);
    probe("R4 3E0", 1'b1, 32'h3E0, 2'b00, 1'b0, 1'b0, 1'b1, DS);
    probe("R4 3BB", 1'b1, 32'h3BB, 2'b00, 1'b0, 1'b0, 1'b1, ONC);
    probe("R4 3AF", 1'b1, 32'h3AF, 2'b00, 1'b0, 1'b0, 1'b1, DS);
    probe("R10 3BC", 1'b1, 32'h3BC, 2'b00, 1'b0, 1'b0, 1'b1, DS);
    probe("R10 3BF", 1'b1, 32'h3BF, 2'b00, 1'b0, 1'b0, 1'b1, DS);
  endtask

  task automatic t_mono;
    probe("R8 mem lo",  1'b0, 32'h000B0000, 2'b00, 1'b1, 1'b0, 1'b1, DS);
    probe("R8 mem hi",  1'b0, 32'h000B7FFF, 2'b00, 1'b1, 1'b0, 1'b1, DS);
    probe("R8 B8000",   1'b0, 32'h000B8000, 2'b00, 1'b1, 1'b0, 1'b1, ONC);
    probe("R8 port bp", 1'b0, 32'h000B0000, 2'b10, 1'b1, 1'b0, 1'b0, DS);
    probe("R8 3B4",     1'b1, 32'h3B4, 2'b00, 1'b1, 1'b0, 1'b1, DS);
    probe("R8 3BA",     1'b1, 32'h3BA, 2'b01, 1'b1, 1'b0, 1'b0, DS);
    probe("R8 3BF",     1'b1, 32'h3BF, 2'b00, 1'b1, 1'b0, 1'b1, DS);
    probe("R8 3B0",     1'b1, 32'h3B0, 2'b00, 1'b1, 1'b0, 1'b1, ONC);
    probe("R8 3B6",     1'b1, 32'h3B6, 2'b00, 1'b1, 1'b0, 1'b1, ONC);
    probe("R8 3C0",     1'b1, 32'h3C0, 2'b00, 1'b1, 1'b0, 1'b1, ONC);
    probe("R8 absent",  1'b0, 32'h000B0000, 2'b00, 1'b0, 1'b0, 1'b1, ONC);
  endtask

  task automatic t_decode_width;
    probe("R9 alias 10b",   1'b1, 32'h73C0, 2'b00, 1'b0, 1'b0, 1'b1, ONC);
    probe("R9 alias 16b",   1'b1, 32'h73C0, 2'b00, 1'b0, 1'b1, 1'b1, DS);
    probe("R9 exact 16b",   1'b1, 32'h03C0, 2'b00, 1'b0, 1'b1, 1'b1, ONC);
    probe("R9 mono alias",  1'b1, 32'h07B4, 2'b00, 1'b1, 1'b0, 1'b1, DS);
    probe("R9 mono 16b",    1'b1, 32'h07B4, 2'b00, 1'b1, 1'b1, 1'b1, DS);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1'b1; is_io = 1'b0; addr = 32'h000A0000; vga_en = 2'b10;
    mda = 1'b0; d16 = 1'b0; igd = 1'b0;
    @(negedge clk);
    check("R2 b2b first", {dest_valid, dest}, {1'b1, P1});
    addr = 32'h000C8000;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 b2b second", {dest_valid, dest}, {1'b1, DS});
    @(negedge clk);
    check("R2 drain", {dest_valid, dest}, 5'b0);
  endtask

  initial begin
    t_reset();
    t_mem_window();
    t_priority();
    t_io_ports();
    t_mono();
    t_decode_width();
    t_back_to_back();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule